// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach PHY management registers over a two-wire serial management link. The host writes a 32-bit command word, and an optional 32-bit extended-address word, through a simple write port. It reads both words back combinationally. The block divides its own reference clock (nominally 25 MHz) into the MDC clock. It serialises Clause 22 or Clause 45 frames onto MDIO and drives a separate output-enable, so that an external pad can tri-state the line.

Status flags in the command word track the transfer. Once a read completes, the PHY's 16-bit reply replaces the data field. A background poll mode can repeatedly read PHY register 1 without any host involvement.

Top module: `mdio_master`

## Requirements
- R1: After reset, both readback words are zero, MDC is low and the MDIO output enable is low.
- R2: A command write with bit 23 (go) set reads back with go=1 and bit 27 (busy)=0 on the next cycle. One cycle later go=0 and busy=1. The block is idle only when both bits are 0.
- R3: Bits [26:24] select the MDC period in reference cycles: 0 and 1 give 4, 2 gives 6, 3 gives 8, 4 gives 10, 5 gives 32, 6 gives 64, 7 gives 128. Busy lasts exactly (bits sent) × period cycles.
- R4: A Clause 22 frame is sent MSB first and sampled on MDC rising edges. It consists of 32 ones (left out when bit 22 is set), start 01, opcode 10 (read, bit 21=1) or 01 (write), PHY address 00000, register address from bits [20:16], turnaround, then 16 data bits.
- R5: On a read frame the output enable is low for the 2 turnaround and 16 data bits. When busy falls, the 16 bits sampled on MDC rising edges appear in [15:0].
- R6: On a write frame the turnaround is driven as 10, followed by data bits [15:0].
- R7: The extended word holds the 16-bit register address in [15:0] and the device address in [20:16]. Bits [25:21] (port address) always read 0.
- R8: With bit 30 set, two frames are sent. The first is an address frame (start 00, opcode 00, port 0, device, turnaround 10, 16-bit register address). The second uses opcode 11 (read) or 01 (write). The register field [20:16] is not used.
- R9: With bit 28 set, the block launches Clause 22 reads of register 1 back to back, one cycle after the previous one ends, and stores each result in [15:0].
- R10: While go or busy is set, command writes are ignored, except that a write with bit 28 clear turns off polling. Polling then stops after the frame in progress.
- R11: At period 128, a Clause 45 transfer with preamble completes within 30000 reference cycles (1.2 ms).
- R12: MDIO and its enable change only while MDC is low; they are held while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 = command word, 1 = extended-address word |
| wr_data | input | 32 | Host write data |
| ctrl_rdata | output | 32 | Command word readback |
| ext_rdata | output | 32 | Extended-address word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Serial data in |

## Verification
The go flag is due on the first cycle after the write and busy on the second. From that point busy is due to fall after exactly (bits × period) cycles. Read data is due in [15:0] on that same cycle.

The bench counts falling reference edges from the busy-rise sample until busy is seen low and compares the count with that product. It records each MDIO bit at MDC rising edges and checks the record against a bit list built from the requirements. It feeds reply bits indexed by the same edge count. On every falling reference edge, a monitor checks that MDIO is held while MDC stays high.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int TIMEOUT_CYC = 30000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] ext_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [15:0] data_q, xreg_q, rx_q;
  logic [4:0]  reg_q, dev_q;
  logic [2:0]  sel_q;
  logic        rd_q, nopre_q, start_q, busy_q, ap_q, ext_q;
  logic        cur_ext, cur_rd, in2, rd_frame;
  logic [6:0]  div_q, idx_q, half, last_idx, pre_off;
  logic [63:0] sh_q;

  function automatic logic [31:0] body(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] dev, input logic [15:0] d);
    return {st, op, 5'd0, dev, 2'b10, d};
  endfunction

  function automatic logic [63:0] packed_frame(input logic nopre, input logic [31:0] b);
    return nopre ? {b, 32'h0} : {32'hFFFF_FFFF, b};
  endfunction

  always_comb begin
    case (sel_q)
      3'd2:    half = 7'd3;
      3'd3:    half = 7'd4;
      3'd4:    half = 7'd5;
      3'd5:    half = 7'd16;
      3'd6:    half = 7'd32;
      3'd7:    half = 7'd64;
      default: half = 7'd2;
    endcase
  end

  assign last_idx = nopre_q ? 7'd31 : 7'd63;
  assign pre_off  = nopre_q ? 7'd0 : 7'd32;

  logic active, go_host, go_poll, l_ext, l_rd;
  logic [4:0]  l_reg;
  logic [31:0] first_body, second_body;
  assign active  = start_q | busy_q;
  assign go_host = start_q;
  assign go_poll = !active && ap_q && !(wr_en && !wr_sel);
  assign l_ext   = go_host & ext_q;
  assign l_rd    = go_host ? rd_q : 1'b1;
  assign l_reg   = go_host ? reg_q : 5'd1;
  assign first_body  = l_ext ? body(2'b00, 2'b00, dev_q, xreg_q)
                             : body(2'b01, l_rd ? 2'b10 : 2'b01, l_reg, data_q);
  assign second_body = body(2'b00, cur_rd ? 2'b11 : 2'b01, dev_q, data_q);

  logic unused_bits;
  assign unused_bits = ^{wr_data[31], wr_data[29]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0; xreg_q <= '0; rx_q <= '0; reg_q <= '0; dev_q <= '0; sel_q <= '0;
      rd_q <= 1'b0; nopre_q <= 1'b0; start_q <= 1'b0; busy_q <= 1'b0; ap_q <= 1'b0;
      ext_q <= 1'b0; cur_ext <= 1'b0; cur_rd <= 1'b0; in2 <= 1'b0; rd_frame <= 1'b0;
      div_q <= '0; idx_q <= '0; sh_q <= '0; mdc <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) begin
        if (active) ap_q <= ap_q & wr_data[28];
        else begin
          data_q  <= wr_data[15:0];
          reg_q   <= wr_data[20:16];
          rd_q    <= wr_data[21];
          nopre_q <= wr_data[22];
          start_q <= wr_data[23];
          sel_q   <= wr_data[26:24];
          ap_q    <= wr_data[28];
          ext_q   <= wr_data[30];
        end
      end
      if (wr_en && wr_sel && !active) begin
        dev_q  <= wr_data[20:16];
        xreg_q <= wr_data[15:0];
      end
      if (start_q) start_q <= 1'b0;
      if (go_host || go_poll) begin
        busy_q   <= 1'b1;
        cur_ext  <= l_ext;
        cur_rd   <= l_rd;
        in2      <= 1'b0;
        rd_frame <= !l_ext && l_rd;
        sh_q     <= packed_frame(nopre_q, first_body);
        idx_q    <= '0;
        div_q    <= '0;
        mdc      <= 1'b0;
      end else if (busy_q) begin
        if (div_q == half - 7'd1) begin
          div_q <= '0;
          mdc   <= !mdc;
          if (!mdc) begin
            if (rd_frame && idx_q >= pre_off + 7'd16) rx_q <= {rx_q[14:0], mdio_i};
          end else if (idx_q == last_idx) begin
            if (cur_ext && !in2) begin
              in2      <= 1'b1;
              rd_frame <= cur_rd;
              sh_q     <= packed_frame(nopre_q, second_body);
              idx_q    <= '0;
            end else begin
              busy_q <= 1'b0;
              if (cur_rd) data_q <= rx_q;
            end
          end else begin
            idx_q <= idx_q + 7'd1;
            sh_q  <= {sh_q[62:0], 1'b0};
          end
        end else begin
          div_q <= div_q + 7'd1;
        end
      end
    end
  end

  assign mdio_o  = busy_q & sh_q[63];
  assign mdio_oe = busy_q && !(rd_frame && idx_q >= pre_off + 7'd14);
  assign ctrl_rdata = {1'b0, ext_q, 1'b0, ap_q, busy_q, sel_q, start_q, nopre_q, rd_q, reg_q, data_q};
  assign ext_rdata  = {11'd0, dev_q, xreg_q};

  int busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_q) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  a_r2_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  a_r2_go_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> busy_q);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdio_oe && !mdc));
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(ctrl_rdata[26:0]));
  a_r11_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> busy_cnt < TIMEOUT_CYC);
  a_r12_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 40;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, mdio_i;
  logic [31:0] wr_data = '0, ctrl_rdata, ext_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_master dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rdata(ctrl_rdata), .ext_rdata(ext_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, r12_bad = 0;
  logic [1:0] exp_a [0:255];
  logic [1:0] got_a [0:255];
  logic       resp_a [0:255];
  int exp_n = 0, rise_cnt = 0;

  assign mdio_i = (rise_cnt < 256) ? resp_a[rise_cnt] : 1'b1;

  always @(posedge mdc) begin
    if (rise_cnt < 256) got_a[rise_cnt] = mdio_oe ? {1'b0, mdio_o} : 2'd2;
    rise_cnt++;
  end

  logic pmdc = 1'b0, po = 1'b0, poe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mdc && pmdc && (mdio_o !== po || mdio_oe !== poe)) r12_bad++;
    pmdc = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int ratio(input int code);
    case (code)
      2: return 6; 3: return 8; 4: return 10; 5: return 32; 6: return 64; 7: return 128;
      default: return 4;
    endcase
  endfunction

  task automatic put(input logic b, input logic r = 1'b1, input bit rel = 0);
    exp_a[exp_n] = rel ? 2'd2 : {1'b0, b};
    resp_a[exp_n] = r;
    exp_n++;
  endtask

  task automatic frame(input bit nopre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] a, input bit rd, input logic [15:0] d, input logic [15:0] rsp);
    if (!nopre) for (int i = 0; i < 32; i++) put(1'b1);
    put(st[1]); put(st[0]); put(op[1]); put(op[0]);
    for (int i = 0; i < 5; i++) put(1'b0);
    for (int i = 4; i >= 0; i--) put(a[i]);
    if (rd) begin
      put(1'b0, 1'b1, 1); put(1'b0, 1'b1, 1);
      for (int i = 15; i >= 0; i--) put(1'b0, rsp[i], 1);
    end else begin
      put(1'b1); put(1'b0);
      for (int i = 15; i >= 0; i--) put(d[i]);
    end
  endtask

  task automatic clr();
    exp_n = 0;
    for (int i = 0; i < 256; i++) begin exp_a[i] = 2'd0; got_a[i] = 2'd3; resp_a[i] = 1'b1; end
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit ext, input bit ap, input int sel, input bit go,
                                     input bit nopre, input bit rd, input logic [4:0] rg, input logic [15:0] d);
    return {1'b0, ext, 1'b0, ap, 1'b0, 3'(sel), go, nopre, rd, rg, d};
  endfunction

  task automatic cmp_stream(input string req);
    int bad = -1;
    for (int i = 0; i < exp_n; i++) if (bad < 0 && got_a[i] !== exp_a[i]) bad = i;
    chk(bad < 0 && rise_cnt == exp_n, req, (bad < 0) ? rise_cnt : {got_a[bad], 16'(bad)},
        (bad < 0) ? exp_n : {exp_a[bad], 16'(bad)});
  endtask

  task automatic run_txn(input string req, input bit ext, input bit rd, input int sel, input bit nopre,
                         input logic [4:0] rg, input logic [4:0] dev, input logic [15:0] xreg,
                         input logic [15:0] d, input logic [15:0] rsp, input bit inj);
    int n = 0;
    clr();
    if (ext) begin
      frame(nopre, 2'b00, 2'b00, dev, 0, xreg, 16'h0);
      frame(nopre, 2'b00, rd ? 2'b11 : 2'b01, dev, rd, d, rsp);
    end else frame(nopre, 2'b01, rd ? 2'b10 : 2'b01, rg, rd, d, rsp);
    if (ext) host_wr(1'b1, {6'd0, 5'h1F, dev, xreg});
    rise_cnt = 0;
    host_wr(1'b0, mk(ext, 0, sel, 1, nopre, rd, rg, d));
    chk(ctrl_rdata[23] && !ctrl_rdata[27], {req, " R2 go seen"}, ctrl_rdata, 32'h0080_0000);
    @(negedge clk);
    chk(!ctrl_rdata[23] && ctrl_rdata[27], {req, " R2 busy follows"}, ctrl_rdata, 32'h0800_0000);
    do begin
      @(negedge clk); n++;
      if (inj && n == 20) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = mk(0, 0, 0, 1, 0, 1, 5'h0A, 16'h5A5A); end
      if (inj && n == 21) wr_en = 1'b0;
    end while (ctrl_rdata[27] && n < 40000);
    chk(n == exp_n * ratio(sel), {req, " R3 busy length"}, n, exp_n * ratio(sel));
    if (sel == 7) chk(n <= 30000, {req, " R11 time limit"}, n, 30000);
    cmp_stream({req, " R4 R6 R8 bit stream"});
    chk(ctrl_rdata[15:0] == (rd ? rsp : d) && ctrl_rdata[20:16] == rg,
        {req, " R5 R10 data field"}, ctrl_rdata[20:0], {rg, rd ? rsp : d});
    if (inj) begin
      @(negedge clk); @(negedge clk);
      chk(!ctrl_rdata[27] && !ctrl_rdata[23], {req, " R10 no relaunch"}, ctrl_rdata, 32'h0);
    end
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    chk(ctrl_rdata == 0 && ext_rdata == 0 && !mdc && !mdio_oe, "R1 reset state",
        {ctrl_rdata[31:2], mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rdata == 0 && !mdio_oe, "R1 after release", ctrl_rdata, 32'h0);

    host_wr(1'b1, {6'd0, 5'h1F, 5'h03, 16'h8001});
    chk(ext_rdata == {11'd0, 5'h03, 16'h8001}, "R7 ext layout port zero", ext_rdata, {11'd0, 5'h03, 16'h8001});

    run_txn("c22 rd /4 code1", 0, 1, 1, 0, 5'h02, 5'h0, 16'h0, 16'h0, 16'hA5C3, 0);
    run_txn("c22 wr /8 nopre", 0, 0, 3, 1, 5'h1F, 5'h0, 16'h0, 16'h1234, 16'h0, 1);
    run_txn("c22 rd /32", 0, 1, 5, 1, 5'h11, 5'h0, 16'h0, 16'h0, 16'h0F0F, 0);
    run_txn("c22 wr /4 code0", 0, 0, 0, 0, 5'h05, 5'h0, 16'h0, 16'h9C31, 16'h0, 0);
    run_txn("c22 wr /10", 0, 0, 4, 1, 5'h0C, 5'h0, 16'h0, 16'h7E01, 16'h0, 0);
    run_txn("c22 rd /64", 0, 1, 6, 1, 5'h07, 5'h0, 16'h0, 16'h0, 16'h3C96, 0);
    run_txn("c45 rd /6", 1, 1, 2, 0, 5'h15, 5'h03, 16'h8001, 16'h0, 16'hBEEF, 0);
    run_txn("c45 wr /128", 1, 0, 7, 0, 5'h00, 5'h07, 16'h0042, 16'hC0DE, 16'h0, 0);

    begin
      int n = 0;
      clr();
      frame(1, 2'b01, 2'b10, 5'd1, 1, 16'h0, 16'h1357);
      rise_cnt = 0;
      host_wr(1'b0, mk(0, 1, 0, 0, 1, 0, 5'h0, 16'h0));
      chk(ctrl_rdata[28] && !ctrl_rdata[27], "R9 poll armed", ctrl_rdata, 32'h1000_0000);
      @(negedge clk);
      chk(ctrl_rdata[27], "R9 poll launches", ctrl_rdata, 32'h0800_0000);
      do begin @(negedge clk); n++; end while (ctrl_rdata[27] && n < 5000);
      chk(n == 128, "R9 poll frame length", n, 128);
      chk(ctrl_rdata[15:0] == 16'h1357, "R9 poll result", ctrl_rdata[15:0], 16'h1357);
      cmp_stream("R9 poll reads register 1");
      clr();
      frame(1, 2'b01, 2'b10, 5'd1, 1, 16'h0, 16'hE2D4);
      rise_cnt = 0;
      @(negedge clk);
      chk(ctrl_rdata[27], "R9 poll repeats", ctrl_rdata, 32'h0800_0000);
      host_wr(1'b0, 32'h0000_FFFF);
      chk(!ctrl_rdata[28] && ctrl_rdata[27], "R10 poll off while busy", ctrl_rdata, 32'h0800_0000);
      n = 0;
      do begin @(negedge clk); n++; end while (ctrl_rdata[27] && n < 5000);
      chk(ctrl_rdata[15:0] == 16'hE2D4, "R10 frame finished, write ignored", ctrl_rdata[15:0], 16'hE2D4);
      cmp_stream("R9 second poll frame");
      repeat (6) @(negedge clk);
      chk(!ctrl_rdata[27] && !ctrl_rdata[23] && !mdio_oe, "R10 poll stopped", ctrl_rdata, 32'h0);
    end

    chk(r12_bad == 0, "R12 MDIO held while MDC high", r12_bad, 0);
    finish_run();
  end
endmodule